// File: doc/BRIEF.md
# Serial Audio Word-Length Converter

This block takes a two-channel serial audio stream (bit clock, word-select, serial data) and sends each received word back out on the same bit clock and word-select framing, at an output length that may differ from the input length. When the output word is longer, the input word fills the upper bits and every added low-order bit copies the input sign bit. When it is shorter, the surplus low-order input bits are discarded. Slots of a half-frame past the output length carry zero.

The three serial inputs are oversampled by the system clock, so the whole block runs in a single clock domain. Each word is re-emitted in the half-frame of the same channel one frame after it was received.

Operation starts on a rising edge of the run-enable input. At that moment the block compares the longer of the two configured lengths with half the measured number of bit clocks per frame. If the length fits, the block starts. If it does not, a sticky error flag is set instead and a maskable interrupt is raised. The error flag is cleared by a write-one-to-clear pulse, and every new run-enable edge repeats the check.

Top module: `audio_word_resizer`

## Requirements
- R1: The serial data is MSB first. The left channel is carried while word-select is low. Bit k of a word is sampled on the (k+1)-th bit-clock rising edge after the word-select change; the rise on which word-select changes counts as the 0th. A word is re-emitted in the same channel's half-frame of the next frame, with the same bit timing.
- R2: The input and output lengths are selected by 2-bit codes: 0 selects 16 bits, 1 selects 20 bits, and 2 or 3 selects 24 bits.
- R3: When the output is longer than the input, the first output bits equal the input word, and every further output bit up to the output length equals the input MSB.
- R4: When the output is shorter than the input, the output carries the leading output-length bits of the input, and the remaining low-order input bits are dropped.
- R5: Output slots at or beyond the output length within a half-frame are 0.
- R6: The bit clocks per frame are counted as bit-clock rises between successive word-select rising edges. On a rising edge of run_en the check passes when twice the longer configured length is no more than that count, and running then goes to 1.
- R7: If the check fails, or no full frame has yet been measured, len_err is set to 1 and running goes to 0.
- R8: irq is 1 exactly when len_err is 1 and irq_mask is 0. The mask does not clear len_err.
- R9: A one-cycle pulse on err_clr clears len_err. A later rising edge of run_en runs the check again with the current settings.
- R10: After reset, running, len_err, irq and sd_out are all 0. While running is 0, sd_out stays 0.
- R11: Taking run_en to 0 returns running to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial inputs |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_in | input | 1 | Serial bit clock |
| ws_in | input | 1 | Word-select (0 = left channel) |
| sd_in | input | 1 | Serial input data |
| in_len_sel | input | 2 | Input word length code |
| out_len_sel | input | 2 | Output word length code |
| run_en | input | 1 | Rising edge requests start; low stops |
| irq_mask | input | 1 | 1 suppresses irq |
| err_clr | input | 1 | Pulse clears the length error flag |
| sd_out | output | 1 | Serial output data |
| running | output | 1 | Conversion active |
| len_err | output | 1 | Length check failed (sticky) |
| irq | output | 1 | Interrupt request |

## Verification
Each output bit is driven about three system clocks after the bit-clock rise that precedes its slot. The bench therefore samples sd_out at the end of each bit-clock low phase, just before the rise on which a receiver would latch it. A word's expected bits are compared one frame after it was sent, in the half-frame of the same channel, and the last slot of each half-frame is taken from the first rise of the following half-frame. running and len_err settle two system clocks after run_en rises. irq follows len_err combinationally, so the status checks wait several clocks after each enable or clear pulse before sampling.

// File: rtl/awr_pkg.sv
package awr_pkg;
   localparam int unsigned LEN_W = 5;

   // length code decode: 0 -> 16, 1 -> 20, 2/3 -> 24
   function automatic logic [LEN_W-1:0] len_of(input logic [1:0] code);
      case (code)
         2'd0:    len_of = 5'd16;
         2'd1:    len_of = 5'd20;
         default: len_of = 5'd24;
      endcase
   endfunction
endpackage

// File: rtl/awr_sync.sv
module awr_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk,
   input  logic ws,
   input  logic sd,
   output logic rise,
   output logic ws_s,
   output logic sd_s
);
   logic [STAGES-1:0] b_sh, w_sh, d_sh;
   logic              b_prev;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("awr_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         b_sh   <= '0;
         w_sh   <= '0;
         d_sh   <= '0;
         b_prev <= 1'b0;
      end else begin
         b_sh   <= {b_sh[STAGES-2:0], bclk};
         w_sh   <= {w_sh[STAGES-2:0], ws};
         d_sh   <= {d_sh[STAGES-2:0], sd};
         b_prev <= b_sh[STAGES-1];
      end
   end

   assign rise = b_sh[STAGES-1] & ~b_prev;
   assign ws_s = w_sh[STAGES-1];
   assign sd_s = d_sh[STAGES-1];
endmodule

// File: rtl/awr_rx.sv
module awr_rx
   import awr_pkg::*;
#(
   parameter int unsigned MAX_W = 24,
   parameter int unsigned CNT_W = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        rise,
   input  logic                        ws_s,
   input  logic                        sd_s,
   input  logic [LEN_W-1:0]            in_len,
   output logic                        ws_chg,
   output logic [1:0][MAX_W-1:0]       hold,
   output logic [CNT_W-1:0]            frame_cnt,
   output logic                        meas_valid
);
   localparam logic [LEN_W-1:0] MAXW_L = LEN_W'(MAX_W);
   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   logic             ws_last, seen_rise;
   logic [CNT_W-1:0] pos, fcnt;
   logic [MAX_W-1:0] sh, sh_nxt, aligned;

   assign ws_chg  = rise && (ws_s != ws_last);
   assign sh_nxt  = (pos < CNT_W'(in_len)) ? {sh[MAX_W-2:0], sd_s} : sh;
   assign aligned = sh_nxt << (MAXW_L - in_len);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ws_last    <= 1'b0;
         pos        <= '0;
         sh         <= '0;
         hold       <= '0;
         fcnt       <= '0;
         frame_cnt  <= '0;
         seen_rise  <= 1'b0;
         meas_valid <= 1'b0;
      end else if (rise) begin
         ws_last <= ws_s;
         if (ws_chg) begin
            hold[ws_last] <= aligned;
            sh            <= '0;
            pos           <= '0;
         end else begin
            sh <= sh_nxt;
            if (pos != CNT_TOP) pos <= pos + 1'b1;
         end
         if (ws_chg && ws_s) begin
            if (seen_rise) begin
               frame_cnt  <= fcnt;
               meas_valid <= 1'b1;
            end
            seen_rise <= 1'b1;
            fcnt      <= CNT_W'(1);
         end else if (fcnt != CNT_TOP) begin
            fcnt <= fcnt + 1'b1;
         end
      end
   end

   // R6
   meas_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(meas_valid) |-> $past(ws_chg && ws_s));
endmodule

// File: rtl/awr_tx.sv
module awr_tx
   import awr_pkg::*;
#(
   parameter int unsigned MAX_W = 24,
   parameter int unsigned CNT_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  rise,
   input  logic                  ws_chg,
   input  logic                  ws_s,
   input  logic                  running,
   input  logic [1:0][MAX_W-1:0] hold,
   input  logic [LEN_W-1:0]      in_len,
   input  logic [LEN_W-1:0]      out_len,
   output logic                  sd_out
);
   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   logic [MAX_W-1:0] src, ext_word, tx_sh;
   logic [CNT_W-1:0] tpos;

   assign src = hold[ws_s];

   // sign fill of the slots past the input length
   generate
      for (genvar k = 0; k < MAX_W; k++) begin : g_ext
         assign ext_word[MAX_W-1-k] = (LEN_W'(k) < in_len) ? src[MAX_W-1-k] : src[MAX_W-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_sh  <= '0;
         tpos   <= '0;
         sd_out <= 1'b0;
      end else begin
         if (ws_chg) begin
            tx_sh <= ext_word << 1;
            tpos  <= CNT_W'(1);
         end else if (rise) begin
            tx_sh <= tx_sh << 1;
            if (tpos != CNT_TOP) tpos <= tpos + 1'b1;
         end
         if (!running)
            sd_out <= 1'b0;
         else if (ws_chg)
            sd_out <= ext_word[MAX_W-1];
         else if (rise)
            sd_out <= (tpos < CNT_W'(out_len)) && tx_sh[MAX_W-1];
      end
   end

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !running |=> !sd_out);

   // R5
   pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && !ws_chg && (tpos >= CNT_W'(out_len))) |=> !sd_out);
endmodule

// File: rtl/awr_ctrl.sv
module awr_ctrl
   import awr_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run_en,
   input  logic               err_clr,
   input  logic               irq_mask,
   input  logic [LEN_W-1:0]   in_len,
   input  logic [LEN_W-1:0]   out_len,
   input  logic [CNT_W-1:0]   frame_cnt,
   input  logic               meas_valid,
   output logic               running,
   output logic               len_err,
   output logic               irq
);
   logic               en_q, start, fits;
   logic [LEN_W-1:0]   longest;
   logic [CNT_W-1:0]   need;

   generate
      if (CNT_W < LEN_W + 1) begin : g_bad_cnt
         $error("awr_ctrl: CNT_W too small for the length check");
      end
   endgenerate

   assign start   = run_en & ~en_q;
   assign longest = (in_len > out_len) ? in_len : out_len;
   assign need    = CNT_W'({longest, 1'b0});
   assign fits    = meas_valid && (need <= frame_cnt);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         running <= 1'b0;
         len_err <= 1'b0;
      end else begin
         en_q <= run_en;
         if (!run_en)    running <= 1'b0;
         else if (start) running <= fits;
         if (start && !fits) len_err <= 1'b1;
         else if (err_clr)   len_err <= 1'b0;
      end
   end

   assign irq = len_err & ~irq_mask;

   // R6 R7
   start_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (running || len_err));

   // R9
   err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(len_err) |-> $past(err_clr));

   // R11
   stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> !running);
endmodule

// File: rtl/audio_word_resizer.sv
module audio_word_resizer
   import awr_pkg::*;
#(
   parameter int unsigned MAX_W       = 24,
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bclk_in,
   input  logic       ws_in,
   input  logic       sd_in,
   input  logic [1:0] in_len_sel,
   input  logic [1:0] out_len_sel,
   input  logic       run_en,
   input  logic       irq_mask,
   input  logic       err_clr,
   output logic       sd_out,
   output logic       running,
   output logic       len_err,
   output logic       irq
);
   generate
      if (MAX_W < 24 || MAX_W > 31) begin : g_bad_width
         $error("audio_word_resizer: MAX_W must lie in 24..31");
      end
   endgenerate

   logic                  rise, ws_s, sd_s, ws_chg, meas_valid;
   logic [1:0][MAX_W-1:0] hold;
   logic [CNT_W-1:0]      frame_cnt;
   logic [LEN_W-1:0]      in_len, out_len;

   assign in_len  = len_of(in_len_sel);
   assign out_len = len_of(out_len_sel);

   awr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .bclk(bclk_in), .ws(ws_in), .sd(sd_in),
      .rise(rise), .ws_s(ws_s), .sd_s(sd_s));

   awr_rx #(.MAX_W(MAX_W), .CNT_W(CNT_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .rise(rise), .ws_s(ws_s), .sd_s(sd_s),
      .in_len(in_len), .ws_chg(ws_chg), .hold(hold),
      .frame_cnt(frame_cnt), .meas_valid(meas_valid));

   awr_tx #(.MAX_W(MAX_W), .CNT_W(CNT_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .rise(rise), .ws_chg(ws_chg), .ws_s(ws_s),
      .running(running), .hold(hold), .in_len(in_len), .out_len(out_len),
      .sd_out(sd_out));

   awr_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .err_clr(err_clr),
      .irq_mask(irq_mask), .in_len(in_len), .out_len(out_len),
      .frame_cnt(frame_cnt), .meas_valid(meas_valid),
      .running(running), .len_err(len_err), .irq(irq));
endmodule

// File: tb/audio_word_resizer_test.sv
module audio_word_resizer_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bclk_in = 1'b0, ws_in = 1'b0, sd_in = 1'b0;
   logic [1:0] in_len_sel = 2'd0, out_len_sel = 2'd0;
   logic run_en = 1'b0, irq_mask = 1'b0, err_clr = 1'b0;
   logic sd_out, running, len_err, irq;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   audio_word_resizer uut (
      .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .ws_in(ws_in), .sd_in(sd_in),
      .in_len_sel(in_len_sel), .out_len_sel(out_len_sel), .run_en(run_en),
      .irq_mask(irq_mask), .err_clr(err_clr), .sd_out(sd_out),
      .running(running), .len_err(len_err), .irq(irq));

   typedef struct packed {
      logic [7:0]  half;
      logic [1:0]  isel;
      logic [1:0]  osel;
      logic        mask;
      logic        err;
      logic [23:0] wl;
      logic [23:0] wr;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{8'd32, 2'd0, 2'd2, 1'b0, 1'b0, 24'h00A5C3, 24'h001234},  // R3 sign fill
      '{8'd32, 2'd2, 2'd0, 1'b0, 1'b0, 24'h89ABCD, 24'h7F00FF},  // R4 truncate
      '{8'd24, 2'd3, 2'd2, 1'b0, 1'b0, 24'hC0FFEE, 24'h123456},  // R2 code 3, exact fit
      '{8'd20, 2'd1, 2'd0, 1'b0, 1'b0, 24'h09ABCD, 24'h054321},  // R6 20 bits in 40
      '{8'd20, 2'd2, 2'd0, 1'b0, 1'b1, 24'h111111, 24'h222222},  // R7 too long
      '{8'd20, 2'd0, 2'd2, 1'b1, 1'b1, 24'h00F00F, 24'h000FF0},  // R8 masked
      '{8'd16, 2'd0, 2'd1, 1'b0, 1'b1, 24'h008001, 24'h007FFE},  // R7 output governs
      '{8'd32, 2'd1, 2'd1, 1'b0, 1'b0, 24'h0FEDCB, 24'h00F0F0}   // R5 zero tail
   };

   function automatic int blen(input logic [1:0] c);
      return (c == 2'd0) ? 16 : (c == 2'd1) ? 20 : 24;
   endfunction

   function automatic logic ebit(input logic [23:0] w, input int l, input int m, input int k);
      if (k >= m) return 1'b0;
      if (k < l)  return w[l-1-k];
      return w[l-1];
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_rise(input logic w, input logic d, output logic cap);
      bclk_in = 1'b0; ws_in = w; sd_in = d;
      repeat (4) @(negedge clk);
      cap = sd_out;
      bclk_in = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic do_reset();
      run_en = 1'b0; err_clr = 1'b0;
      bclk_in = 1'b0; ws_in = 1'b0; sd_in = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // send halves 0..NH-1; run_en rises after half 3 when en_at4 is set
   task automatic stream(input int hh, input int l, input logic [23:0] wl, input logic [23:0] wr,
                         input int nh, input bit en_at4, ref logic [63:0] cap [12]);
      logic [23:0] prevw;
      logic c;
      prevw = '0;
      for (int h = 0; h < 12; h++) cap[h] = '0;
      for (int h = 0; h < nh; h++) begin
         logic [23:0] w;
         w = h[0] ? wr : wl;
         for (int i = 0; i < hh; i++) begin
            logic d;
            d = 1'b0;
            if (i >= 1 && (i - 1) < l) d = w[l-i];
            else if (i == 0 && h > 0 && l == hh) d = prevw[0];
            do_rise(h[0], d, c);
            if (i >= 1) cap[h][i-1] = c;
            else if (h > 0) cap[h-1][hh-1] = c;
         end
         prevw = w;
         if (h == 3 && en_at4) begin
            run_en = 1'b1;
            repeat (4) @(negedge clk);
         end
      end
   endtask

   initial begin : main
      logic [63:0] cap [12];
      do_reset();
      // R10 reset state
      chk(running == 1'b0 && len_err == 1'b0 && irq == 1'b0 && sd_out == 1'b0, "R10 reset outputs",
          {60'd0, running, len_err, irq, sd_out}, 64'd0);

      for (int v = 0; v < NV; v++) begin
         vec_t t;
         int hh, l, m;
         t = VECS[v];
         hh = int'(t.half); l = blen(t.isel); m = blen(t.osel);
         do_reset();
         in_len_sel = t.isel; out_len_sel = t.osel; irq_mask = t.mask;
         stream(hh, l, t.wl, t.wr, 11, 1'b1, cap);
         // output halves 4..9 carry input halves 2..7 (same channel, next frame)
         for (int o = 4; o < 10; o++) begin
            logic [63:0] e;
            logic [23:0] w;
            w = o[0] ? t.wr : t.wl;
            e = '0;
            if (!t.err)
               for (int k = 0; k < hh; k++) e[k] = ebit(w, l, m, k);
            chk(cap[o] == e, $sformatf("R1 R3 R4 R5 vec%0d half%0d", v, o), cap[o], e);
         end
         chk(running == !t.err, $sformatf("R6 R7 running vec%0d", v), {63'd0, running}, {63'd0, !t.err});
         chk(len_err == t.err, $sformatf("R7 len_err vec%0d", v), {63'd0, len_err}, {63'd0, t.err});
         chk(irq == (t.err && !t.mask), $sformatf("R8 irq vec%0d", v), {63'd0, irq},
             {63'd0, (t.err && !t.mask)});
         run_en = 1'b0;
         repeat (3) @(negedge clk);
      end

      // R9: clear the flag, then retry with lengths that fit
      do_reset();
      in_len_sel = 2'd2; out_len_sel = 2'd2; irq_mask = 1'b0;
      stream(20, 24, 24'hABCDEF, 24'h13579B, 4, 1'b1, cap);
      chk(len_err == 1'b1 && running == 1'b0, "R9 first attempt fails", {62'd0, len_err, running}, 64'd2);
      run_en = 1'b0;
      in_len_sel = 2'd0; out_len_sel = 2'd0;
      repeat (2) @(negedge clk);
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
      repeat (2) @(negedge clk);
      chk(len_err == 1'b0 && irq == 1'b0, "R9 flag cleared", {62'd0, len_err, irq}, 64'd0);
      run_en = 1'b1;
      repeat (4) @(negedge clk);
      chk(running == 1'b1 && len_err == 1'b0, "R9 retry passes", {62'd0, running, len_err}, 64'd2);

      // R11 and R10: stop, then output stays quiet with a stream present
      run_en = 1'b0;
      repeat (3) @(negedge clk);
      chk(running == 1'b0, "R11 stop", {63'd0, running}, 64'd0);
      stream(20, 16, 24'h00FFFF, 24'h00FFFF, 6, 1'b0, cap);
      chk(cap[4] == 64'd0 && cap[3] == 64'd0, "R10 idle output zero", cap[4] | cap[3], 64'd0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule